// File: doc/BRIEF.md
# Three-Plane Hit Coincidence Finder

This block searches for straight-line hit triplets across three detector planes without looping over every combination. In a fill phase, hits from the two outer planes (A and C) arrive in any order, and each hit sets one bit in a 64-bin occupancy array for its plane. The plane-C array is kept in mirrored bin order. Because of this, the line condition xA + xC = 2·xB becomes a fixed offset between the two arrays. That offset depends only on the centre coordinate.

In the query phase, centre-plane (B) hits are offered one at a time. For each accepted B hit, the block aligns the mirrored C array against the A array by an offset of 2·xB − 63 bins. It tests every A bin at once, using an OR-AND rule that also accepts the two bins next to the exact partner. Every A bin that passes is then reported on its own output cycle, lowest bin first, together with the B coordinate and the partner C bin. A halt output holds off further B hits while more than one result is still pending. Fake combinations may be reported; later stages remove them. A synchronous clear empties both arrays between events.

Top module: `trip_coinc_finder`

## Requirements
- R1: After reset both arrays are empty, `m_vld` is 0 and `halt` is 0.
- R2: A plane-A hit (`a_vld` with `a_x` = bin) sets that bin. The bin is seen by a B hit accepted on the next clock edge or later, but not by one accepted on the same edge. Repeated hits to a bin are harmless.
- R3: A plane-C hit (`c_vld` with `c_x` = bin) sets that bin under the same timing as R2.
- R4: For an accepted B hit, an A bin xa pairs with C bin xc when xa + xc = 2·b_x. The pair is reported with `m_xa` = xa, `m_xc` = xc and `m_xb` = b_x.
- R5: A pair whose sum is 2·b_x − 1 or 2·b_x + 1 also matches. Each A bin reports one C partner, chosen in this order: exact sum, then sum − 1, then sum + 1.
- R6: A pair whose sum differs from 2·b_x by 2 or more never matches. Partner bins outside 0..63 count as empty, including at bins 0 and 63.
- R7: All matches of one B hit are emitted on consecutive cycles in ascending `m_xa`. `m_last` is 1 only on the final one.
- R8: `halt` is 1 exactly while two or more matches remain, counting the one on the outputs. A `b_vld` seen while `halt` is 1 is ignored.
- R9: A B hit that has no match produces no output cycle and does not raise `halt`.
- R10: `clr` empties both arrays in one cycle. Fills presented in the same cycle as `clr` are dropped.
- R11: The first match of a B hit appears in the cycle after the edge that accepted it. A B hit offered during a final (`m_last`) cycle is accepted and its matches follow without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty both occupancy arrays |
| a_vld | input | 1 | Plane-A hit strobe |
| a_x | input | 6 | Plane-A hit bin |
| c_vld | input | 1 | Plane-C hit strobe |
| c_x | input | 6 | Plane-C hit bin |
| b_vld | input | 1 | Centre-plane hit strobe |
| b_x | input | 6 | Centre-plane hit bin |
| halt | output | 1 | Hold off centre-plane hits |
| m_vld | output | 1 | Match output valid |
| m_last | output | 1 | Final match of the current B hit |
| m_xb | output | 6 | Centre bin of the match |
| m_xa | output | 6 | Plane-A bin of the match |
| m_xc | output | 6 | Plane-C bin of the match |

## Verification
A fill becomes visible one edge after it is presented, because it passes through one array register. An accepted B hit passes through one result register, so its first match is due in the cycle after the accepting edge. Each further match follows one cycle after the previous one. The bench drives on the falling edge and samples all outputs on the next falling edge, so every check compares the registered state at a known cycle. The expected list for each B hit comes from a direct bin-pair search written in the bench.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  // Which neighbour supplied the C partner for a reported A bin.
  typedef enum logic [1:0] {
    MK_EXACT = 2'd0,
    MK_MINUS = 2'd1,
    MK_PLUS  = 2'd2
  } mkind_e;
endpackage

// File: rtl/tcf_occ_array.sv
module tcf_occ_array #(
  parameter int  NB      = 64,
  parameter bit  REVERSE = 1'b0,
  localparam int XW      = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit_vld,
  input  logic [XW-1:0] hit_x,
  output logic [NB-1:0] occ
);
  logic [XW-1:0] slot;

  generate
    if (REVERSE) begin : g_rev
      assign slot = XW'(NB-1) - hit_x;
    end else begin : g_fwd
      assign slot = hit_x;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       occ <= '0;
    else if (clr)     occ <= '0;
    else if (hit_vld) occ[slot] <= 1'b1;
  end

  // R10: a clear leaves the array empty on the next cycle.
  p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ == '0));
  // R2 / R3: a fill outside a clear is present on the next cycle.
  p_fill_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && !clr) |=> occ[$past(slot)]);
endmodule

// File: rtl/tcf_match.sv
module tcf_match #(
  parameter int  NB = 64,
  localparam int XW = $clog2(NB)
) (
  input  logic [NB-1:0] occ_a,
  input  logic [NB-1:0] occ_cr,
  input  logic [XW-1:0] xb,
  output logic [NB-1:0] hit_e,
  output logic [NB-1:0] hit_m,
  output logic [NB-1:0] hit_any
);
  int shift_d;
  logic [NB-1:0] hit_p;

  // Offset between A bin index and mirrored C index for an exact line.
  function automatic int line_shift(input logic [XW-1:0] b);
    return 2 * int'(b) - (NB - 1);
  endfunction

  // Bit i = a[i] AND rc[i - d + off]; indices off the array read as 0.
  function automatic logic [NB-1:0] aligned_and(input logic [NB-1:0] a,
                                                input logic [NB-1:0] rc,
                                                input int d, input int off);
    logic [NB-1:0] r;
    r = '0;
    for (int i = 0; i < NB; i++) begin
      int j;
      j = i - d + off;
      if (j >= 0 && j < NB) r[i] = a[i] & rc[j];
    end
    return r;
  endfunction

  assign shift_d = line_shift(xb);
  assign hit_e   = aligned_and(occ_a, occ_cr, shift_d, 0);
  assign hit_m   = aligned_and(occ_a, occ_cr, shift_d, 1);
  assign hit_p   = aligned_and(occ_a, occ_cr, shift_d, -1);
  assign hit_any = hit_e | hit_m | hit_p;
endmodule

// File: rtl/tcf_emit.sv
module tcf_emit
  import tcf_pkg::*;
#(
  parameter int  NB = 64,
  localparam int XW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [NB-1:0] ld_any,
  input  logic [NB-1:0] ld_e,
  input  logic [NB-1:0] ld_m,
  input  logic [XW-1:0] ld_xb,
  output logic          m_vld,
  output logic          m_last,
  output logic          halt,
  output logic [XW-1:0] m_xa,
  output logic [XW-1:0] m_xb,
  output mkind_e        m_kind
);
  logic [NB-1:0] pend, pend_e, pend_m, rest;
  logic [XW-1:0] xb_q;

  function automatic logic [XW-1:0] low_idx(input logic [NB-1:0] v);
    logic [XW-1:0] r;
    r = '0;
    for (int i = NB - 1; i >= 0; i--) if (v[i]) r = XW'(i);
    return r;
  endfunction

  assign rest   = pend & (pend - NB'(1));
  assign m_vld  = |pend;
  assign halt   = |rest;
  assign m_last = m_vld && !halt;
  assign m_xa   = low_idx(pend);
  assign m_xb   = xb_q;
  assign m_kind = pend_e[m_xa] ? MK_EXACT : (pend_m[m_xa] ? MK_MINUS : MK_PLUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      pend_e <= '0;
      pend_m <= '0;
      xb_q   <= '0;
    end else if (take) begin
      pend   <= ld_any;
      pend_e <= ld_e;
      pend_m <= ld_m;
      xb_q   <= ld_xb;
    end else begin
      pend <= rest;
    end
  end

  // R8: halt only while further matches follow the current one.
  p_halt_more_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (m_vld && !m_last));
  // R7: a non-final match is followed by one at a higher A bin.
  p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_vld && !m_last) |=> (m_vld && (m_xa > $past(m_xa))));
  // R7: after the final match, output goes idle unless a new B hit is taken.
  p_last_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_last && !take) |=> !m_vld);
endmodule

// File: rtl/trip_coinc_finder.sv
module trip_coinc_finder
  import tcf_pkg::*;
#(
  parameter int  NB = 64,
  localparam int XW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          a_vld,
  input  logic [XW-1:0] a_x,
  input  logic          c_vld,
  input  logic [XW-1:0] c_x,
  input  logic          b_vld,
  input  logic [XW-1:0] b_x,
  output logic          halt,
  output logic          m_vld,
  output logic          m_last,
  output logic [XW-1:0] m_xb,
  output logic [XW-1:0] m_xa,
  output logic [XW-1:0] m_xc
);
  logic [NB-1:0] occ_a, occ_cr, hit_e, hit_m, hit_any;
  logic          take;
  mkind_e        m_kind;

  // C partner from the centre bin, A bin and neighbour choice.
  function automatic logic [XW-1:0] partner_c(input logic [XW-1:0] xb,
                                              input logic [XW-1:0] xa,
                                              input mkind_e k);
    int v;
    v = 2 * int'(xb) - int'(xa);
    if (k == MK_MINUS)     v = v - 1;
    else if (k == MK_PLUS) v = v + 1;
    return XW'(v);
  endfunction

  assign take = b_vld && !halt;

  tcf_occ_array #(.NB(NB), .REVERSE(1'b0)) u_arr_a (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .hit_vld(a_vld), .hit_x(a_x), .occ(occ_a));

  tcf_occ_array #(.NB(NB), .REVERSE(1'b1)) u_arr_c (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .hit_vld(c_vld), .hit_x(c_x), .occ(occ_cr));

  tcf_match #(.NB(NB)) u_match (
    .occ_a(occ_a), .occ_cr(occ_cr), .xb(b_x),
    .hit_e(hit_e), .hit_m(hit_m), .hit_any(hit_any));

  tcf_emit #(.NB(NB)) u_emit (
    .clk(clk), .rst_n(rst_n), .take(take),
    .ld_any(hit_any), .ld_e(hit_e), .ld_m(hit_m), .ld_xb(b_x),
    .m_vld(m_vld), .m_last(m_last), .halt(halt),
    .m_xa(m_xa), .m_xb(m_xb), .m_kind(m_kind));

  assign m_xc = partner_c(m_xb, m_xa, m_kind);

  // R9: a B hit taken while plane A is empty produces no output.
  p_empty_no_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && occ_a == '0) |=> !m_vld);
  // R11: a B hit taken with a candidate shows a match on the next cycle.
  p_first_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit_any != '0) |=> (m_vld && m_xb == $past(b_x)));
endmodule

// File: tb/trip_coinc_finder_tb.sv
module trip_coinc_finder_tb;
  typedef struct packed {
    logic [63:0] am;
    logic [63:0] cm;
    logic [5:0]  xb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{64'(1) << 10, 64'(1) << 20, 6'd15},                                  // R4 exact
    '{64'(1) << 10, 64'(1) << 21, 6'd15},                                  // R5 plus
    '{64'(1) << 10, 64'(1) << 19, 6'd15},                                  // R5 minus
    '{64'(1) << 10, 64'(1) << 22, 6'd15},                                  // R6 off by 2
    '{64'(1) << 0,  (64'(1) << 0) | (64'(1) << 1), 6'd0},                  // R6 low edge
    '{64'(1) << 63, 64'(1) << 62, 6'd63},                                  // R6 high edge
    '{(64'(1) << 5) | (64'(1) << 20) | (64'(1) << 40),
      (64'(1) << 25) | (64'(1) << 10), 6'd15},                             // R7 two
    '{64'(1) << 30, (64'(1) << 29) | (64'(1) << 31), 6'd30},               // R5 order
    '{64'hF, (64'(1) << 60) | (64'(1) << 59) | (64'(1) << 58) | (64'(1) << 57), 6'd30}, // R7 four
    '{64'(1) << 7, 64'd0, 6'd7}                                            // R9 none
  };

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic a_vld = 1'b0, c_vld = 1'b0, b_vld = 1'b0;
  logic [5:0] a_x = '0, c_x = '0, b_x = '0;
  logic halt, m_vld, m_last;
  logic [5:0] m_xb, m_xa, m_xc;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  int exp_n;
  int exp_xa [64];
  int exp_xc [64];

  always #10 clk = ~clk;

  trip_coinc_finder u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .a_vld(a_vld), .a_x(a_x), .c_vld(c_vld), .c_x(c_x),
    .b_vld(b_vld), .b_x(b_x), .halt(halt), .m_vld(m_vld), .m_last(m_last),
    .m_xb(m_xb), .m_xa(m_xa), .m_xc(m_xc));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Independent pair search: ascending A bin, partner exact, then -1, then +1.
  task automatic build_ref(input logic [63:0] am, input logic [63:0] cm, input int xb);
    exp_n = 0;
    for (int xa = 0; xa < 64; xa++) begin
      if (am[xa]) begin
        int t;
        int pick;
        t = 2 * xb - xa;
        pick = -1;
        if (t >= 0 && t < 64 && cm[t]) pick = t;
        else if (t - 1 >= 0 && t - 1 < 64 && cm[t - 1]) pick = t - 1;
        else if (t + 1 >= 0 && t + 1 < 64 && cm[t + 1]) pick = t + 1;
        if (pick >= 0) begin
          exp_xa[exp_n] = xa;
          exp_xc[exp_n] = pick;
          exp_n++;
        end
      end
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic fill(input logic [63:0] am, input logic [63:0] cm);
    for (int b = 0; b < 64; b++) begin
      if (am[b] || cm[b]) begin
        @(negedge clk);
        a_vld = am[b]; a_x = 6'(b);
        c_vld = cm[b]; c_x = 6'(b);
      end
    end
    @(negedge clk); a_vld = 1'b0; c_vld = 1'b0;
  endtask

  // Called at the negedge right after the accepting edge.
  task automatic expect_seq(input int xb, input string req);
    for (int k = 0; k < exp_n; k++) begin
      chk(m_vld == 1'b1, req, int'(m_vld), 1);
      chk(m_xa == 6'(exp_xa[k]), req, int'(m_xa), exp_xa[k]);
      chk(m_xc == 6'(exp_xc[k]), req, int'(m_xc), exp_xc[k]);
      chk(m_xb == 6'(xb), req, int'(m_xb), xb);
      chk(m_last == (k == exp_n - 1), {req, " R7 last"}, int'(m_last), int'(k == exp_n - 1));
      chk(halt == (k < exp_n - 1), {req, " R8 halt"}, int'(halt), int'(k < exp_n - 1));
      @(negedge clk);
    end
    chk(m_vld == 1'b0, {req, " idle"}, int'(m_vld), 0);
    chk(halt == 1'b0, {req, " R9 halt idle"}, int'(halt), 0);
  endtask

  task automatic query(input int xb, input string req);
    @(negedge clk); b_vld = 1'b1; b_x = 6'(xb);
    @(negedge clk); b_vld = 1'b0;
    expect_seq(xb, req);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(m_vld == 1'b0, "R1 m_vld", int'(m_vld), 0);
    chk(halt == 1'b0, "R1 halt", int'(halt), 0);
    exp_n = 0;
    query(20, "R1 empty arrays");

    // Vector table
    for (int v = 0; v < NV; v++) begin
      do_clr();
      fill(VECS[v].am, VECS[v].cm);
      build_ref(VECS[v].am, VECS[v].cm, int'(VECS[v].xb));
      query(int'(VECS[v].xb), $sformatf("R4/R5/R6 vec%0d", v));
    end

    // R2 R3: same-edge fill not seen, next-edge fill seen; duplicate hit harmless
    do_clr();
    @(negedge clk); a_vld = 1'b1; a_x = 6'd12; c_vld = 1'b1; c_x = 6'd12;
    b_vld = 1'b1; b_x = 6'd12;
    @(negedge clk); a_vld = 1'b0; c_vld = 1'b0; b_vld = 1'b0;
    exp_n = 0;
    expect_seq(12, "R2 same-edge fill");
    @(negedge clk); a_vld = 1'b1; a_x = 6'd12;
    @(negedge clk); a_vld = 1'b0;
    build_ref(64'(1) << 12, 64'(1) << 12, 12);
    query(12, "R3 next-edge fill");

    // R10: clr drops a same-cycle fill
    do_clr();
    @(negedge clk); clr = 1'b1; a_vld = 1'b1; a_x = 6'd3;
    @(negedge clk); clr = 1'b0; a_vld = 1'b0; c_vld = 1'b1; c_x = 6'd3;
    @(negedge clk); c_vld = 1'b0;
    exp_n = 0;
    query(3, "R10 clr drops fill");

    // R8: B hit during halt is ignored
    do_clr();
    fill((64'(1) << 5) | (64'(1) << 20) | (64'(1) << 50),
         (64'(1) << 25) | (64'(1) << 10) | (64'(1) << 50));
    @(negedge clk); b_vld = 1'b1; b_x = 6'd15;
    @(negedge clk); b_x = 6'd50;   // halt is high here
    chk(halt == 1'b1, "R8 halt during first", int'(halt), 1);
    chk(m_xa == 6'd5 && m_xc == 6'd25, "R8 first", int'(m_xa), 5);
    @(negedge clk); b_vld = 1'b0;  // last cycle of xb=15
    chk(m_last == 1'b1 && m_xa == 6'd20 && m_xc == 6'd10 && m_xb == 6'd15,
        "R8 second", int'(m_xa), 20);
    @(negedge clk);
    chk(m_vld == 1'b0, "R8 ignored B", int'(m_vld), 0);
    build_ref(64'(1) << 50, 64'(1) << 50, 50);
    query(50, "R8 later B taken");

    // R11: B offered on a final cycle is taken with no gap
    @(negedge clk); b_vld = 1'b1; b_x = 6'd15;
    @(negedge clk);
    chk(m_xa == 6'd5 && halt == 1'b1, "R11 first next cycle", int'(m_xa), 5);
    b_x = 6'd15;                   // held, ignored while halt
    @(negedge clk);
    chk(m_last == 1'b1 && m_xa == 6'd20, "R11 last", int'(m_xa), 20);
    b_x = 6'd50;                   // offered on final cycle
    @(negedge clk); b_vld = 1'b0;
    chk(m_vld == 1'b1 && m_xb == 6'd50 && m_xa == 6'd50 && m_xc == 6'd50,
        "R11 back-to-back", int'(m_xb), 50);
    @(negedge clk);
    chk(m_vld == 1'b0, "R11 drain", int'(m_vld), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule